// File: doc/BRIEF.md
# Serial Flash Command Acceptance and Write-Protection Gate

This block sits behind the instruction decoder of a serial-peripheral flash slave. It decides whether each decoded instruction is carried out or dropped. The decoder presents one opcode per instruction with a strobe. One cycle later the gate answers with a single-cycle accept or reject pulse. When the accepted instruction modifies the array or the status register, the gate also starts the array engine in that same cycle. The gate keeps three pieces of state. The first is the write-enable latch. The second is a power-up inhibit timer that starts when the supply-good input rises. The third is a deep power-down flag. In power-down mode only one instruction is honoured.

The status-register write is further governed by a two-bit protect mode and the write-protect pin. The same block also owns the hold function of the serial interface. Hold is armed and released only on a falling serial-clock edge. While hold is active it masks data shifting and turns the data output off. When chip select is raised during a hold, the gate drops the hold and emits a pulse that resets the instruction state.

The supply-good input acts as the block's reset. While it is low, every register is cleared and no strobe is answered.

Top module: `flash_wp_gate`

## Requirements
- R1: While `pwr_good` is 0, the following outputs read 0 one cycle later, whatever the strobe does: `acc`, `rej`, `eng_start`, `wel`, `pd_mode`, `puw_done` and `hold_on`.
- R2: `puw_done` rises after `PUW_CYCLES` clock edges with `pwr_good` high. While `puw_done` is 0, the following opcodes are rejected and `wel` stays 0: write enable (0x06), page program (0x02), sector erase (0x20), block erase (0xD8), chip erase (0xC7) and status write (0x01).
- R3: `wel` is 0 after power-up. An accepted 0x06 sets `wel`. Write disable (0x04) is accepted outside power-down and clears `wel`.
- R4: 0x02, 0x20, 0xD8, 0xC7 and 0x01 are accepted only if `wel` is 1 when they are issued. Each acceptance of one of these pulses `eng_start` in the same cycle as `acc`.
- R5: An `eng_done` pulse clears `wel` on the next edge. The only exception is an accepted 0x06 in that same cycle, which wins.
- R6: Power-down (0xB9) is accepted and sets `pd_mode`. While `pd_mode` is 1, every opcode except release (0xAB) is rejected and changes no state. An accepted 0xAB clears `pd_mode`.
- R7: Status write (0x01) additionally depends on `srp`. With `srp`=00 it is allowed. With `srp`=01 it is allowed only when `wp_n` is 1. With `srp`=10 or 11 it is always rejected.
- R8: While `hold_on` is 1, both `do_oe` and `shift_en` are 0. Otherwise `do_oe` follows `so_oe` with `cs_n` low, and `shift_en` marks a rising `sclk` with `cs_n` low.
- R9: `hold_on` changes only at a sampled falling edge of `sclk`, where it takes the value of `!hold_n`. The exception is chip select going high.
- R10: A rising `cs_n` while `hold_on` is 1 yields a one-cycle `cmd_rst` pulse and clears `hold_on`. With `cs_n` high, `hold_on` stays 0.
- R11: Every strobe gets exactly one of `acc` or `rej`, one cycle later. Without a strobe, neither is raised. Other opcodes (e.g. read 0x03) are accepted outside power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good | input | 1 | Supply-good level, low holds the block in reset |
| op_valid | input | 1 | Decoded-instruction strobe |
| op_code | input | 8 | Decoded opcode |
| srp | input | 2 | Status-register protect mode |
| wp_n | input | 1 | Write-protect pin, active low |
| eng_done | input | 1 | Array engine completion pulse |
| hold_n | input | 1 | Hold pin, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock sampled in the core domain |
| so_oe | input | 1 | Output enable requested by the shifter |
| acc | output | 1 | Instruction accepted pulse |
| rej | output | 1 | Instruction rejected pulse |
| eng_start | output | 1 | Start pulse to the array engine |
| wel | output | 1 | Write-enable latch |
| pd_mode | output | 1 | Deep power-down active |
| puw_done | output | 1 | Power-up inhibit expired |
| hold_on | output | 1 | Hold condition active |
| shift_en | output | 1 | Qualified serial-clock rise for the shifter |
| do_oe | output | 1 | Gated data output enable (0 = high impedance) |
| cmd_rst | output | 1 | Instruction-state reset pulse |

## Verification
Directed sequences walk one opcode through each gate in turn: before and after the inhibit timer, with the latch clear and set, across all four protect modes with both pin levels, and in and out of power-down. A rejection can therefore be traced to the exact condition that caused it. A random phase mixes all opcodes with random protect settings and completion pulses that collide with strobes. This separates the precedence of a same-cycle completion against write enable and write disable. The hold sequence moves `hold_n` while the serial clock is idle and then on a falling clock. This distinguishes edge-qualified hold from level-following hold. It ends by lifting chip select mid-hold.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PD   = 8'hB9;
  localparam logic [7:0] OP_RPD  = 8'hAB;

  typedef enum logic [1:0] {
    SRP_SOFT = 2'b00,
    SRP_PIN  = 2'b01,
    SRP_LCKA = 2'b10,
    SRP_LCKB = 2'b11
  } srp_mode_e;

  // Array-modifying opcode (program or erase)
  function automatic logic is_array_write(input logic [7:0] op);
    return (op == OP_PP) || (op == OP_SE) || (op == OP_BE) || (op == OP_CE);
  endfunction

  // Opcode that requires the write-enable latch and starts the engine
  function automatic logic needs_wel(input logic [7:0] op);
    return is_array_write(op) || (op == OP_WRSR);
  endfunction

  // Opcode blocked by the power-up inhibit window
  function automatic logic puw_gated(input logic [7:0] op);
    return needs_wel(op) || (op == OP_WREN);
  endfunction

  // Status-register write permission from protect mode and pin
  function automatic logic sr_write_ok(input logic [1:0] srp, input logic wp_n);
    case (srp_mode_e'(srp))
      SRP_SOFT: return 1'b1;
      SRP_PIN:  return wp_n;
      default:  return 1'b0;
    endcase
  endfunction

  // Full acceptance decision for one opcode
  function automatic logic cmd_ok(input logic [7:0] op, input logic pd,
                                  input logic wel, input logic puw,
                                  input logic [1:0] srp, input logic wp_n);
    if (pd)                     return (op == OP_RPD);
    if (puw_gated(op) && !puw)  return 1'b0;
    if (needs_wel(op) && !wel)  return 1'b0;
    if (op == OP_WRSR)          return sr_write_ok(srp, wp_n);
    return 1'b1;
  endfunction

endpackage

// File: rtl/wpg_puw_timer.sv
module wpg_puw_timer #(
  parameter int unsigned PUW_CYCLES = 4096
) (
  input  logic clk,
  input  logic pwr_good,
  output logic expired
);
  localparam int unsigned CW = $clog2(PUW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PUW_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/wpg_cmd_gate.sv
module wpg_cmd_gate
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       puw_done,
  input  logic [1:0] srp,
  input  logic       wp_n,
  input  logic       eng_done,
  output logic       acc,
  output logic       rej,
  output logic       eng_start,
  output logic       wel,
  output logic       pd_mode,
  output logic       grant_w
);
  logic wel_nxt, pd_nxt;

  assign grant_w = op_valid && cmd_ok(op_code, pd_mode, wel, puw_done, srp, wp_n);

  always_comb begin
    wel_nxt = wel;
    pd_nxt  = pd_mode;
    if (eng_done) wel_nxt = 1'b0;
    if (grant_w) begin
      case (op_code)
        OP_WREN: wel_nxt = 1'b1;
        OP_WRDI: wel_nxt = 1'b0;
        OP_PD:   pd_nxt  = 1'b1;
        OP_RPD:  pd_nxt  = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      acc       <= 1'b0;
      rej       <= 1'b0;
      eng_start <= 1'b0;
      wel       <= 1'b0;
      pd_mode   <= 1'b0;
    end else begin
      acc       <= grant_w;
      rej       <= op_valid && !grant_w;
      eng_start <= grant_w && needs_wel(op_code);
      wel       <= wel_nxt;
      pd_mode   <= pd_nxt;
    end
  end
endmodule

// File: rtl/wpg_hold_ctl.sv
module wpg_hold_ctl (
  input  logic clk,
  input  logic pwr_good,
  input  logic hold_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic so_oe,
  output logic hold_on,
  output logic shift_en,
  output logic do_oe,
  output logic cmd_rst,
  output logic sclk_fall
);
  logic sclk_q, cs_q, sclk_rise, cs_rise;

  assign sclk_fall = sclk_q && !sclk;
  assign sclk_rise = !sclk_q && sclk;
  assign cs_rise   = !cs_q && cs_n;

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      hold_on <= 1'b0;
      cmd_rst <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      cmd_rst <= cs_rise && hold_on;
      if (cs_n)           hold_on <= 1'b0;
      else if (sclk_fall) hold_on <= !hold_n;
    end
  end

  assign shift_en = sclk_rise && !cs_n && !hold_on;
  assign do_oe    = so_oe && !cs_n && !hold_on;
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate #(
  parameter int unsigned PUW_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic [1:0] srp,
  input  logic       wp_n,
  input  logic       eng_done,
  input  logic       hold_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       so_oe,
  output logic       acc,
  output logic       rej,
  output logic       eng_start,
  output logic       wel,
  output logic       pd_mode,
  output logic       puw_done,
  output logic       hold_on,
  output logic       shift_en,
  output logic       do_oe,
  output logic       cmd_rst
);
  logic sclk_fall;
  logic grant_w;

  wpg_puw_timer #(.PUW_CYCLES(PUW_CYCLES)) u_timer (
    .clk(clk), .pwr_good(pwr_good), .expired(puw_done)
  );

  wpg_cmd_gate u_gate (
    .clk(clk), .pwr_good(pwr_good), .op_valid(op_valid), .op_code(op_code),
    .puw_done(puw_done), .srp(srp), .wp_n(wp_n), .eng_done(eng_done),
    .acc(acc), .rej(rej), .eng_start(eng_start), .wel(wel),
    .pd_mode(pd_mode), .grant_w(grant_w)
  );

  wpg_hold_ctl u_hold (
    .clk(clk), .pwr_good(pwr_good), .hold_n(hold_n), .cs_n(cs_n),
    .sclk(sclk), .so_oe(so_oe), .hold_on(hold_on), .shift_en(shift_en),
    .do_oe(do_oe), .cmd_rst(cmd_rst), .sclk_fall(sclk_fall)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker
  import wpg_pkg::*;
(
  input logic       clk,
  input logic       pwr_good,
  input logic       op_valid,
  input logic [7:0] op_code,
  input logic       eng_done,
  input logic       cs_n,
  input logic       acc,
  input logic       rej,
  input logic       eng_start,
  input logic       wel,
  input logic       pd_mode,
  input logic       puw_done,
  input logic       hold_on,
  input logic       shift_en,
  input logic       do_oe,
  input logic       cmd_rst,
  input logic       sclk_fall
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!pwr_good)
    !(acc && rej));
  a_r11_answer: assert property (@(posedge clk) disable iff (!pwr_good)
    op_valid |=> (acc || rej));
  a_r11_silent: assert property (@(posedge clk) disable iff (!pwr_good)
    !op_valid |=> !(acc || rej));
  a_r4_start_acc: assert property (@(posedge clk) disable iff (!pwr_good)
    eng_start |-> acc);
  a_r4_start_wel: assert property (@(posedge clk) disable iff (!pwr_good)
    eng_start |-> $past(wel));
  a_r2_no_wel_early: assert property (@(posedge clk) disable iff (!pwr_good)
    !puw_done |-> (!wel && !eng_start));
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!pwr_good)
    (eng_done && !(op_valid && op_code == OP_WREN)) |=> !wel);
  a_r6_pd_only_release: assert property (@(posedge clk) disable iff (!pwr_good)
    (pd_mode && op_valid && op_code != OP_RPD) |=> (rej && pd_mode));
  a_r8_hold_masks: assert property (@(posedge clk) disable iff (!pwr_good)
    hold_on |-> (!do_oe && !shift_en));
  a_r9_rise_on_fall: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(hold_on) |-> $past(sclk_fall));
  a_r10_cs_clears: assert property (@(posedge clk) disable iff (!pwr_good)
    cs_n |=> !hold_on);
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!pwr_good)
    cmd_rst |=> !cmd_rst);
endmodule

bind flash_wp_gate wpg_checker u_chk (
  .clk(clk), .pwr_good(pwr_good), .op_valid(op_valid), .op_code(op_code),
  .eng_done(eng_done), .cs_n(cs_n), .acc(acc), .rej(rej),
  .eng_start(eng_start), .wel(wel), .pd_mode(pd_mode), .puw_done(puw_done),
  .hold_on(hold_on), .shift_en(shift_en), .do_oe(do_oe), .cmd_rst(cmd_rst),
  .sclk_fall(sclk_fall)
);

// File: tb/sim_flash_wp_gate.sv
`timescale 1ns/1ps
module sim_flash_wp_gate;
  localparam int unsigned PUW = 40;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, op_valid = 1'b0, wp_n = 1'b1, eng_done = 1'b0;
  logic hold_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, so_oe = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [1:0] srp = 2'b00;
  logic acc, rej, eng_start, wel, pd_mode, puw_done, hold_on, shift_en, do_oe, cmd_rst;

  int tests = 0, fails = 0;
  bit m_wel, m_pd;

  always #2.5 clk = ~clk;

  flash_wp_gate #(.PUW_CYCLES(PUW)) u0 (
    .clk(clk), .pwr_good(pwr_good), .op_valid(op_valid), .op_code(op_code),
    .srp(srp), .wp_n(wp_n), .eng_done(eng_done), .hold_n(hold_n), .cs_n(cs_n),
    .sclk(sclk), .so_oe(so_oe), .acc(acc), .rej(rej), .eng_start(eng_start),
    .wel(wel), .pd_mode(pd_mode), .puw_done(puw_done), .hold_on(hold_on),
    .shift_en(shift_en), .do_oe(do_oe), .cmd_rst(cmd_rst)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // Bench restatement of the acceptance rules
  function automatic bit exp_ok(input logic [7:0] op, input bit pd, input bit w,
                                input bit pu, input logic [1:0] sp, input logic wp);
    bit writes, gated, sr_ok;
    writes = (op == 8'h02) || (op == 8'h20) || (op == 8'hD8) || (op == 8'hC7) || (op == 8'h01);
    gated  = writes || (op == 8'h06);
    sr_ok  = (sp == 2'b00) || (sp == 2'b01 && wp);
    if (pd) return op == 8'hAB;
    if (gated && !pu) return 0;
    if (writes && !w) return 0;
    if (op == 8'h01 && !sr_ok) return 0;
    return 1;
  endfunction

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic issue(input logic [7:0] op, input bit exp_a, input string tag);
    op_code = op; op_valid = 1'b1;
    cyc();
    op_valid = 1'b0;
    chk(acc, exp_a, $sformatf("%s acc op %02h", tag, op));
    chk(rej, !exp_a, $sformatf("%s rej op %02h", tag, op));
  endtask

  initial begin
    @(negedge clk);
    // R1: reset while supply is low, strobe ignored
    op_code = 8'h03; op_valid = 1'b1;
    cyc(); cyc();
    chk(acc, 0, "R1 acc"); chk(rej, 0, "R1 rej"); chk(wel, 0, "R1 wel");
    chk(pd_mode, 0, "R1 pd"); chk(puw_done, 0, "R1 puw"); chk(hold_on, 0, "R1 hold");
    op_valid = 1'b0;
    pwr_good = 1'b1;
    // R2: inhibit window
    issue(8'h06, 0, "R2 wren early");
    chk(wel, 0, "R3 wel after power-up");
    issue(8'h02, 0, "R2 pp early");
    issue(8'h03, 1, "R11 read early");
    chk(puw_done, 0, "R2 timer running");
    repeat (PUW) cyc();
    chk(puw_done, 1, "R2 timer expired");
    // R4 / R3 / R5
    issue(8'h20, 0, "R4 erase without wel");
    issue(8'h06, 1, "R3 wren");
    chk(wel, 1, "R3 wel set");
    issue(8'h02, 1, "R4 pp");
    chk(eng_start, 1, "R4 eng_start");
    cyc(); chk(eng_start, 0, "R4 start one cycle");
    eng_done = 1'b1; cyc(); eng_done = 1'b0;
    chk(wel, 0, "R5 wel cleared by done");
    issue(8'h06, 1, "R3 wren again");
    issue(8'h04, 1, "R3 wrdi");
    chk(wel, 0, "R3 wel cleared by wrdi");
    // R7 protect modes
    issue(8'h06, 1, "R7 wren");
    srp = 2'b01; wp_n = 1'b0;
    issue(8'h01, 0, "R7 pin mode wp low");
    chk(eng_start, 0, "R7 no start");
    wp_n = 1'b1;
    issue(8'h01, 1, "R7 pin mode wp high");
    eng_done = 1'b1; op_code = 8'h06; op_valid = 1'b1; cyc();
    eng_done = 1'b0; op_valid = 1'b0;
    chk(wel, 1, "R5 wren wins over done");
    srp = 2'b10;
    issue(8'h01, 0, "R7 locked mode");
    srp = 2'b00; wp_n = 1'b0;
    issue(8'h01, 1, "R7 soft mode");
    // R6 power-down
    issue(8'hB9, 1, "R6 pd");
    chk(pd_mode, 1, "R6 pd set");
    issue(8'h04, 0, "R6 wrdi ignored");
    chk(wel, 1, "R6 wel untouched");
    issue(8'h03, 0, "R6 read ignored");
    issue(8'hAB, 1, "R6 release");
    chk(pd_mode, 0, "R6 pd cleared");
    // R8 / R9 / R10 hold
    cs_n = 1'b0; so_oe = 1'b1; cyc();
    chk(do_oe, 1, "R8 oe passes");
    sclk = 1'b1; #1 chk(shift_en, 1, "R8 shift passes");
    cyc(); sclk = 1'b0; cyc(); // falling edge, hold_n high
    hold_n = 1'b0; cyc();
    chk(hold_on, 0, "R9 no edge no hold");
    sclk = 1'b1; cyc(); sclk = 1'b0; cyc();
    chk(hold_on, 1, "R9 hold on falling edge");
    chk(do_oe, 0, "R8 oe off in hold");
    sclk = 1'b1; #1 chk(shift_en, 0, "R8 shift masked");
    hold_n = 1'b1; cyc(); cyc();
    chk(hold_on, 1, "R9 release waits for edge");
    cs_n = 1'b1; cyc();
    chk(cmd_rst, 1, "R10 cmd_rst pulse");
    chk(hold_on, 0, "R10 hold cleared");
    cyc(); chk(cmd_rst, 0, "R10 pulse one cycle");
    sclk = 1'b0; so_oe = 1'b0;
    // Random phase (R11, R4, R5, R6, R7)
    void'($urandom(32'd1234));
    m_wel = wel; m_pd = pd_mode;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ops [10] = '{8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01, 8'hB9, 8'hAB, 8'h03};
      logic [7:0] op;
      bit ok, st, dn, ov;
      op = ops[$urandom % 10];
      srp = 2'($urandom); wp_n = 1'($urandom);
      dn = ($urandom % 5) == 0;
      ov = ($urandom % 4) != 0;
      ok = ov && exp_ok(op, m_pd, m_wel, 1, srp, wp_n);
      st = ok && (op == 8'h02 || op == 8'h20 || op == 8'hD8 || op == 8'hC7 || op == 8'h01);
      if (dn) m_wel = 0;
      if (ok && op == 8'h06) m_wel = 1;
      if (ok && op == 8'h04) m_wel = 0;
      if (ok && op == 8'hB9) m_pd = 1;
      if (ok && op == 8'hAB) m_pd = 0;
      op_code = op; op_valid = ov; eng_done = dn;
      cyc();
      op_valid = 1'b0; eng_done = 1'b0;
      chk(acc, ok, $sformatf("R11 rnd acc op %02h", op));
      chk(rej, ov && !ok, $sformatf("R11 rnd rej op %02h", op));
      chk(eng_start, st, $sformatf("R4 rnd start op %02h", op));
      chk(wel, m_wel, $sformatf("R5 rnd wel op %02h", op));
      chk(pd_mode, m_pd, $sformatf("R6 rnd pd op %02h", op));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule